// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical address by walking a two-level page table kept in a word-addressed memory. A requester hands over a virtual address with a valid/ready handshake. The walker adds the top index field to the table base register and reads the first-level entry at that address. That entry gives the base of a second-level table. The walker adds the second index field to that base and reads the final entry. The final entry carries the frame number. The walker places the frame above the untouched page offset and returns the result.

Each entry has a valid bit. When either read returns an invalid entry, the walker ends the walk with a fault response. The response names the level that failed and carries a zeroed address. The response stays on its outputs until the requester takes it. The table base register has its own load port. A load that lands while a walk is in flight is seen only by later requests. The memory port handles one read at a time: a one-cycle request pulse, then a read-data valid strobe at least one cycle later.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1, and rsp_valid and mem_req are 0.
- R2: The virtual address (16 bits by default) splits, from the top, into a 3-bit first index, a 4-bit second index and a 9-bit offset. A good response carries the offset unchanged in rsp_paddr[8:0] and the frame number directly above it.
- R3: After a request is accepted, the walker pulses mem_req for one cycle with mem_addr equal to the table base plus the first index, modulo 2^12.
- R4: A first-level entry is valid when bit 15 is 1, and its bits [11:0] hold the second-level table base. The second read is issued at that base plus the second index, modulo 2^12.
- R5: A second-level entry is valid when bit 15 is 1, and its bits [5:0] hold the frame number. A valid entry gives rsp_fault 0 and rsp_paddr equal to {frame, offset}.
- R6: An invalid first-level entry gives rsp_fault 1, rsp_fault_lvl 0 and rsp_paddr 0, and no second read is issued.
- R7: An invalid second-level entry gives rsp_fault 1, rsp_fault_lvl 1 and rsp_paddr 0.
- R8: The walker accepts requests only while idle. req_ready stays 0 from the accepting edge until the response is taken, and at most one memory read is outstanding at a time.
- R9: While rsp_valid is 1 and rsp_ready is 0, the response outputs hold their values.
- R10: A base load made in the cycle a request is accepted, or while a walk runs, does not change that walk. It applies from the next accepted request on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptbr_load | input | 1 | Write strobe for the table base register |
| ptbr_data | input | 12 | New table base value |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 16 | Virtual address to translate |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_paddr | output | 15 | Physical address ({frame, offset}), 0 on a fault |
| rsp_fault | output | 1 | Walk hit an invalid entry |
| rsp_fault_lvl | output | 1 | Failing level: 0 = first, 1 = second |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 12 | Word address of the read |
| mem_rvalid | input | 1 | Read data valid, at least one cycle after mem_req |
| mem_rdata | input | 16 | Read data |

## Verification
Some internal faults change the physical address. A stale or wrongly summed walk address shows up as a wrong frame on that very response. The walk address can be wrong because an index was extracted badly or because the base was latched at the wrong time. The bench also checks the two read addresses on the memory port, one cycle after each request pulse. A state machine that skips a level or fails to stop on an invalid entry shows in three places: the number of reads per walk, the reported fault level, and whether req_ready comes back only once the response has been taken. Every page number is swept under two table images and several memory latencies. Responses are held back under backpressure so that a state register which moves early shows up as an output changing while it should hold.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int IDX1_W  = 3,
  parameter int IDX2_W  = 4,
  parameter int OFF_W   = 9,
  parameter int MEM_AW  = 12,
  parameter int MEM_DW  = 16,
  parameter int FRAME_W = 6
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               ptbr_load,
  input  logic [MEM_AW-1:0]                  ptbr_data,
  input  logic                               req_valid,
  output logic                               req_ready,
  input  logic [IDX1_W+IDX2_W+OFF_W-1:0]     req_vaddr,
  output logic                               rsp_valid,
  input  logic                               rsp_ready,
  output logic [FRAME_W+OFF_W-1:0]           rsp_paddr,
  output logic                               rsp_fault,
  output logic                               rsp_fault_lvl,
  output logic                               mem_req,
  output logic [MEM_AW-1:0]                  mem_addr,
  input  logic                               mem_rvalid,
  input  logic [MEM_DW-1:0]                  mem_rdata
);
  localparam int VA_W  = IDX1_W + IDX2_W + OFF_W;
  localparam int PA_W  = FRAME_W + OFF_W;
  localparam int VLD_B = MEM_DW - 1;

  typedef enum logic [1:0] {IDLE, READ_L1, READ_L2, RESP} walk_st_t;

  walk_st_t            st_q;
  logic                issued_q;
  logic [MEM_AW-1:0]   ptbr_q;
  logic [MEM_AW-1:0]   addr_q;
  logic [IDX2_W-1:0]   idx2_q;
  logic [OFF_W-1:0]    off_q;
  logic [FRAME_W-1:0]  frame_q;
  logic                fault_q;
  logic                lvl_q;

  logic                rd_done;
  logic                entry_ok;
  logic [MEM_AW-1:0]   idx1_ext;
  logic [MEM_AW-1:0]   idx2_ext;
  logic                unused_bits;

  assign idx1_ext    = MEM_AW'(req_vaddr[VA_W-1 -: IDX1_W]);
  assign idx2_ext    = MEM_AW'(idx2_q);
  assign rd_done     = issued_q && mem_rvalid;
  assign entry_ok    = mem_rdata[VLD_B];
  assign unused_bits = ^mem_rdata;

  assign req_ready     = (st_q == IDLE);
  assign rsp_valid     = (st_q == RESP);
  assign rsp_fault     = rsp_valid && fault_q;
  assign rsp_fault_lvl = rsp_valid && fault_q && lvl_q;
  assign rsp_paddr     = (rsp_valid && !fault_q) ? {frame_q, off_q} : '0;
  assign mem_req       = ((st_q == READ_L1) || (st_q == READ_L2)) && !issued_q;
  assign mem_addr      = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ptbr_q <= '0;
    else if (ptbr_load) ptbr_q <= ptbr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= IDLE;
      issued_q <= 1'b0;
      addr_q   <= '0;
      idx2_q   <= '0;
      off_q    <= '0;
      frame_q  <= '0;
      fault_q  <= 1'b0;
      lvl_q    <= 1'b0;
    end else begin
      case (st_q)
        IDLE: if (req_valid) begin
          addr_q   <= ptbr_q + idx1_ext;
          idx2_q   <= req_vaddr[OFF_W +: IDX2_W];
          off_q    <= req_vaddr[OFF_W-1:0];
          issued_q <= 1'b0;
          fault_q  <= 1'b0;
          lvl_q    <= 1'b0;
          st_q     <= READ_L1;
        end
        READ_L1: begin
          if (!issued_q) issued_q <= 1'b1;
          else if (rd_done) begin
            issued_q <= 1'b0;
            if (!entry_ok) begin
              fault_q <= 1'b1;
              lvl_q   <= 1'b0;
              st_q    <= RESP;
            end else begin
              addr_q <= mem_rdata[MEM_AW-1:0] + idx2_ext;
              st_q   <= READ_L2;
            end
          end
        end
        READ_L2: begin
          if (!issued_q) issued_q <= 1'b1;
          else if (rd_done) begin
            issued_q <= 1'b0;
            if (!entry_ok) begin
              fault_q <= 1'b1;
              lvl_q   <= 1'b1;
            end else begin
              frame_q <= mem_rdata[FRAME_W-1:0];
            end
            st_q <= RESP;
          end
        end
        RESP: if (rsp_ready) st_q <= IDLE;
        default: st_q <= IDLE;
      endcase
    end
  end

  AST_ACCEPT_READS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> mem_req && !req_ready);                         // R3
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req && !req_ready);                                       // R8
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault) && $stable(rsp_fault_lvl)); // R9
  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_valid && rsp_paddr == '0);                                // R6
  AST_LVL_NEEDS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault_lvl |-> rsp_fault);                                               // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid && !mem_req);                                      // R8
  AST_PA_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |=> !rsp_valid || $stable(rsp_paddr[PA_W-1:0]));    // R5
endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;
  localparam int AW = 12;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ptbr_load = 1'b0;
  logic [AW-1:0] ptbr_data = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [15:0] req_vaddr = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b0;
  logic [14:0] rsp_paddr;
  logic rsp_fault, rsp_fault_lvl;
  logic mem_req;
  logic [AW-1:0] mem_addr;
  logic mem_rvalid = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int lat = 0;

  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic pend = 1'b0;
  logic [AW-1:0] pend_addr = '0;
  int pend_cnt = 0;
  int rd_cnt = 0;
  logic [AW-1:0] rd_addr [0:3];

  always #4 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n), .ptbr_load(ptbr_load), .ptbr_data(ptbr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_fault_lvl(rsp_fault_lvl),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req) begin
      pend <= 1'b1;
      pend_addr <= mem_addr;
      pend_cnt <= lat;
      if (rd_cnt < 4) rd_addr[rd_cnt] <= mem_addr;
      rd_cnt <= rd_cnt + 1;
    end else if (pend) begin
      if (pend_cnt == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata <= mem[pend_addr];
        pend <= 1'b0;
      end else pend_cnt <= pend_cnt - 1;
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, got %0d cycles expected < 150000", cycles);
      finish_run();
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int l1_word(input int tbl, input int i);
    if (tbl == 0) return (i == 5) ? 0 : (32'h8000 | (32'h200 + i*16));
    return 32'h8000 | (32'h900 + i*16);
  endfunction

  function automatic int l2_word(input int tbl, input int i, input int j);
    if (tbl == 0) return (((i + j) % 7) == 3) ? 32'h7fff : (32'h8000 | ((i*5 + j*3) % 64));
    return 32'h8000 | ((i + j + 7) % 64);
  endfunction

  task automatic walk(input int tbl, input int base, input logic [15:0] va, input int hold);
    int i, j, e1, e2, l2a;
    logic saw_ready;
    i = va[15:13];
    j = va[12:9];
    e1 = l1_word(tbl, i);
    l2a = ((e1 & 32'hfff) + j) % 4096;
    e2 = l2_word(tbl, i, j);
    @(negedge clk);
    rd_cnt = 0;
    req_vaddr = va;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 req_ready low during walk", req_ready, 0);
    while (!rsp_valid) @(negedge clk);
    check("R3 first read address", rd_addr[0], (base + i) % 4096);
    if (!e1[15]) begin
      check("R6 fault flag", rsp_fault, 1);
      check("R6 fault level", rsp_fault_lvl, 0);
      check("R6 zero address", rsp_paddr, 0);
      check("R6 single read", rd_cnt, 1);
    end else begin
      check("R4 second read address", rd_addr[1], l2a);
      check("R8 two reads", rd_cnt, 2);
      if (!e2[15]) begin
        check("R7 fault flag", rsp_fault, 1);
        check("R7 fault level", rsp_fault_lvl, 1);
        check("R7 zero address", rsp_paddr, 0);
      end else begin
        check("R5 no fault", rsp_fault, 0);
        check("R2 R5 physical address", rsp_paddr, ((e2 & 63) << 9) | va[8:0]);
      end
    end
    if (hold > 0) begin
      logic [14:0] pa0;
      logic f0;
      pa0 = rsp_paddr;
      f0 = rsp_fault;
      for (int k = 0; k < hold; k++) @(negedge clk);
      check("R9 held valid", rsp_valid, 1);
      check("R9 held address", rsp_paddr, pa0);
      check("R9 held fault", rsp_fault, f0);
      check("R8 not ready while response pending", req_ready, 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    saw_ready = req_ready;
    check("R8 ready after response taken", saw_ready, 1);
  endtask

  initial begin
    for (int a = 0; a < 4096; a++) mem[a] = 16'h0;
    for (int i = 0; i < 8; i++) begin
      mem[12'h100 + i] = 16'(l1_word(0, i));
      mem[12'h800 + i] = 16'(l1_word(1, i));
      for (int j = 0; j < 16; j++) begin
        mem[12'h200 + i*16 + j] = 16'(l2_word(0, i, j));
        mem[12'h900 + i*16 + j] = 16'(l2_word(1, i, j));
      end
    end
    repeat (3) @(negedge clk);
    check("R1 reset req_ready", req_ready, 1);
    check("R1 reset rsp_valid", rsp_valid, 0);
    check("R1 reset mem_req", mem_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    ptbr_load = 1'b1; ptbr_data = 12'h100;
    @(negedge clk);
    ptbr_load = 1'b0;

    for (int p = 0; p < 128; p++) begin
      lat = p % 3;
      walk(0, 12'h100, 16'((p << 9) | ((p * 37) % 512)), 0);
    end
    ptbr_load = 1'b1; ptbr_data = 12'h800;
    @(negedge clk);
    ptbr_load = 1'b0;
    for (int p = 0; p < 128; p++) begin
      lat = (p + 1) % 4;
      walk(1, 12'h800, 16'((p << 9) | ((p * 91 + 5) % 512)), (p % 16 == 0) ? 3 : 0);
    end

    // R10: load during a running walk (the helper issues the load at the second negedge)
    lat = 2;
    fork
      walk(1, 12'h800, 16'h2a55, 0);
      begin
        @(negedge clk); @(negedge clk);
        ptbr_load = 1'b1; ptbr_data = 12'h100;
        @(negedge clk);
        ptbr_load = 1'b0;
      end
    join
    walk(0, 12'h100, 16'h2a55, 0); // R10 next request uses new base

    // R10: load in the accept cycle
    fork
      walk(0, 12'h100, 16'hc1ff, 2);
      begin
        @(negedge clk);
        ptbr_load = 1'b1; ptbr_data = 12'h800;
        @(negedge clk);
        ptbr_load = 1'b0;
      end
    join
    walk(1, 12'h800, 16'hc1ff, 0); // R10

    finish_run();
  end
endmodule